// File: doc/BRIEF.md
# Carry-Free Approximate Adder with Error Vector

This block adds two unsigned operands without ever letting a carry travel from one bit position to the next. Before the sum is formed, the two operands are rearranged bit by bit. Bits of equal weight can be swapped between the addends without changing the total, so one internal word takes the OR of each pair and the other takes the AND. Every sum bit is then built only from its own position and the position just below it. The logic depth stays the same whatever the width.

The dropped carry ripple does not disappear. Wherever it would have changed the result, the block sets a bit in a separate error vector. That vector has the same bit weights as the sum. A later stage, such as the error-recovery adder after a partial-product tree, can add it back in full or in part. The approximate sum and the error vector always add up to the exact total.

The outputs are registered. Both results appear one clock after the operands are sampled, and a synchronous active-high reset clears them.

Top module: `nocarry_adder`

## Requirements
- R1: While `rst` is high at a rising edge, both `sum_q` and `err_q` become all zeros at that edge.
- R2: Results are due one clock after sampling. The outputs after rising edge k reflect the operands present at edge k, provided `rst` was low at that edge.
- R3: Bit 0 has no neighbour below it. `sum_q[0]` equals `op_a[0]` XOR `op_b[0]`, and `err_q[0]` is always 0.
- R4: For each position i from 1 to W-1, `sum_q[i]` is 1 exactly when the operand bits at i differ or the operand bits at i-1 are both 1.
- R5: `sum_q[W]`, the top bit, is 1 exactly when both operands have bit W-1 set.
- R6: For i ≥ 1, `err_q[i]` is 1 exactly when the operand bits at i differ and both operand bits at i-1 are 1. Every set error bit therefore has its matching sum bit set as well.
- R7: The error vector never holds two adjacent 1 bits.
- R8: `sum_q + err_q`, with the error vector weighted bit for bit like the sum, equals the exact sum `op_a + op_b`.
- R9: Exchanging the two operands leaves both outputs unchanged.
- R10: When the operands share no set bit (`op_a & op_b == 0`), the error vector is zero and the sum is exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | W | First unsigned addend |
| op_b | input | W | Second unsigned addend |
| sum_q | output | W+1 | Registered approximate sum |
| err_q | output | W | Registered error vector, same bit weights as `sum_q[W-1:0]` |

## Verification
The sum and the error vector are both due exactly one rising edge after their operands are driven. The bench drives each new operand pair on a falling edge and pushes the expected pair into a queue. On the next falling edge, after the single capturing edge has passed, it pops that entry and compares it with the outputs. The reset value is read at a falling edge while reset is still held. The operand-swap check drives the two orders in consecutive cycles and compares the two captured results one cycle apart. The exhaustive sweep over all 65,536 operand pairs checks the bit rules, the adjacency rule and the exact-sum identity for every pair.

// File: rtl/nca_pkg.sv
package nca_pkg;
  // Per-position pre-processed bit pair: OR word bit and AND word bit
  typedef struct packed {
    logic p;
    logic g;
  } bitpair_t;
endpackage

// File: rtl/nca_prep.sv
module nca_prep
  import nca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output bitpair_t     pair_o [W]
);
  // Equal-weight bits are interchangeable, so put the OR in one word, the AND in the other
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pair_o[i].p = a_i[i] | b_i[i];
    assign pair_o[i].g = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/nca_cell.sv
module nca_cell
  import nca_pkg::*;
(
  input  bitpair_t cur_i,
  input  logic     gprev_i,
  output logic     s_o,
  output logic     e_o
);
  logic diff;
  // p & ~g is one exactly when the two original bits differ
  assign diff = cur_i.p & ~cur_i.g;
  assign s_o  = diff | gprev_i;
  assign e_o  = diff & gprev_i;
endmodule

// File: rtl/nca_core.sv
module nca_core
  import nca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o,
  output logic [W-1:0] err_o
);
  bitpair_t pair [W];
  logic [W-1:0] gsh;

  nca_prep #(.W(W)) u_prep (
    .a_i   (a_i),
    .b_i   (b_i),
    .pair_o(pair)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == 0) begin : g_lsb
      assign gsh[i] = 1'b0;
    end else begin : g_mid
      assign gsh[i] = pair[i-1].g;
    end
    nca_cell u_cell (
      .cur_i  (pair[i]),
      .gprev_i(gsh[i]),
      .s_o    (sum_o[i]),
      .e_o    (err_o[i])
    );
  end

  assign sum_o[W] = pair[W-1].g;
endmodule

// File: rtl/nocarry_adder.sv
module nocarry_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W:0]   sum_q,
  output logic [W-1:0] err_q
);
  localparam int XW = W + 2;

  logic [W:0]   sum_c;
  logic [W-1:0] err_c;
  logic         live_q;

  nca_core #(.W(W)) u_core (
    .a_i  (op_a),
    .b_i  (op_b),
    .sum_o(sum_c),
    .err_o(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      err_q  <= '0;
      live_q <= 1'b0;
    end else begin
      sum_q  <= sum_c;
      err_q  <= err_c;
      live_q <= 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && err_q == '0));

  // R8
  exact_total_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (({1'b0, sum_q} + {2'b00, err_q}) ==
                ({2'b00, $past(op_a)} + {2'b00, $past(op_b)})));

  // R7
  no_adjacent_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q & (err_q >> 1)) == '0);

  // R3
  lsb_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err_q[0] == 1'b0);

  // R6
  err_implies_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q & ~sum_q[W-1:0]) == '0);

  // R10
  disjoint_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && (($past(op_a) & $past(op_b)) == '0)) |-> (err_q == '0));
endmodule

// File: tb/nocarry_adder_test.sv
module nocarry_adder_test;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W:0]   s;
  logic [W-1:0] e;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int av;
    int bv;
    int sv;
    int ev;
  } exp_t;

  exp_t q[$];

  nocarry_adder #(.W(W)) uut (
    .clk  (clk),
    .rst  (rst),
    .op_a (a),
    .op_b (b),
    .sum_q(s),
    .err_q(e)
  );

  always #2 clk = ~clk;

  // Reference built from the requirement rules on integers
  function automatic exp_t model(input int av, input int bv);
    exp_t r;
    r.av = av;
    r.bv = bv;
    r.sv = 0;
    r.ev = 0;
    for (int i = 0; i < W; i++) begin
      int ai = (av >> i) & 1;
      int bi = (bv >> i) & 1;
      int lowboth = (i > 0) ? (((av >> (i - 1)) & (bv >> (i - 1))) & 1) : 0;
      int d = (ai != bi) ? 1 : 0;
      if (d == 1 || lowboth == 1) r.sv += (1 << i);
      if (d == 1 && lowboth == 1) r.ev += (1 << i);
    end
    if ((((av >> (W - 1)) & (bv >> (W - 1))) & 1) == 1) r.sv += (1 << W);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic compare_front();
    exp_t x = q.pop_front();
    int si = int'(s);
    int ei = int'(e);
    // R2 R3 R4 R5: sum bits after one cycle
    check(si == x.sv, "R2/R4 sum", si, x.sv);
    // R6: error bits
    check(ei == x.ev, "R6 err", ei, x.ev);
    // R3: bit 0
    check((ei & 1) == 0 && (si & 1) == ((x.av ^ x.bv) & 1), "R3 bit0", si & 1, (x.av ^ x.bv) & 1);
    // R5: top bit
    check(((si >> W) & 1) == (((x.av & x.bv) >> (W - 1)) & 1), "R5 top", (si >> W) & 1,
          ((x.av & x.bv) >> (W - 1)) & 1);
    // R7: no adjacent error bits
    check((ei & (ei >> 1)) == 0, "R7 adjacent", ei, 0);
    // R8: exact total
    check(si + ei == x.av + x.bv, "R8 total", si + ei, x.av + x.bv);
    // R10: disjoint operands give no error
    if ((x.av & x.bv) == 0) check(ei == 0 && si == x.av + x.bv, "R10 disjoint", ei, 0);
  endtask

  task automatic step(input int av, input int bv);
    @(negedge clk);
    if (q.size() > 0) compare_front();
    a = W'(av);
    b = W'(bv);
    q.push_back(model(av, bv));
  endtask

  task automatic flush();
    @(negedge clk);
    while (q.size() > 0) compare_front();
  endtask

  initial begin
    a = '1;
    b = '1;
    repeat (3) @(negedge clk);
    // R1: cleared while reset is held
    check(s == '0 && e == '0, "R1 reset", int'(s), 0);
    rst = 1'b0;
    a = '0;
    b = '0;
    q.push_back(model(0, 0));

    // Directed corners
    step(N - 1, N - 1);
    step(N - 1, 0);
    step(N - 1, 1);
    step(8'h55, 8'h55);
    step(8'hAA, 8'h55);
    step(8'h81, 8'h81);

    // Exhaustive sweep over all pairs
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        step(i, j);
      end
    end
    flush();

    // R9: swapped operands give the same outputs
    for (int k = 0; k < 100; k++) begin
      int av = (k * 37 + 5) % N;
      int bv = (k * 91 + 200) % N;
      logic [W:0]   s1;
      logic [W-1:0] e1;
      @(negedge clk);
      a = W'(av);
      b = W'(bv);
      @(negedge clk);
      s1 = s;
      e1 = e;
      a = W'(bv);
      b = W'(av);
      @(negedge clk);
      check(s == s1 && e == e1, "R9 swap", int'({e, s}), int'({e1, s1}));
    end

    // R1: reset asserted mid-run clears the outputs at the next edge
    @(negedge clk);
    a = '1;
    b = '1;
    rst = 1'b1;
    @(negedge clk);
    check(s == '0 && e == '0, "R1 mid-run reset", int'(s), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule